// File: doc/BRIEF.md
# Exception and Privilege Controller

This block is the exception and privilege unit that sits beside the commit point of a simple in-order integer core. Each cycle the core may present one committing instruction. With it come that instruction's address and the address of the instruction that follows it, a set of exception flags raised by fetch, decode, execute and memory, the operands of a signed add or subtract, and an optional control-register access or exception-return request. Six external interrupt lines are also sampled. The unit picks a single winning cause and records it. It saves the restart address, enters kernel mode, closes the global interrupt enable and, one clock later, asks the fetch stage to redirect to a fixed handler vector.

Four control registers are held here: status, cause, exception PC and bad address. Software reaches them by an index, and only in kernel mode. A read or write from user mode, or an exception return from user mode, is refused and turned into a reserved-instruction exception. An exception return from kernel mode drops to user mode, reopens the interrupt enable and redirects to the saved exception PC.

Top module: `priv_exc_unit`

## Requirements
- R1: After reset the unit is in kernel mode, with the global interrupt enable clear, all six interrupt mask bits clear and no redirect pending. The status register reads 0x0000_0002.
- R2: When an exception or interrupt is taken on a committing instruction, on the next clock edge kernel_mode becomes 1, the interrupt enable clears, and redirect_valid pulses for one cycle with redirect_pc equal to HANDLER_VEC.
- R3: Cause codes, recorded in cause bits 4:0, are: interrupt 0, fetch or load address error 4, store address error 5, fetch bus error 6, data bus error 7, syscall 8, break 9, reserved instruction 10, integer overflow 12, trap 13, floating-point 15. When several synchronous flags are raised together, the winner is the first in this order: fetch address error, fetch bus error, reserved instruction, overflow, syscall, break, trap, floating-point, load address error, store address error, data bus error.
- R4: For codes 4, 5, 6, 7 and 10 the exception PC takes pc_cur, the faulting instruction. For every other code it takes pc_next.
- R5: On codes 4 and 5 the bad-address register takes fault_addr. No other exception changes it.
- R6: Interrupt line i is taken only when the interrupt enable (status bit 0) and mask bit 8+i of status are both 1. If several lines qualify, the lowest number wins, and its number is stored in cause bits 10:8. Any synchronous exception beats an interrupt. An interrupt is not accepted in a cycle that carries a register write or an exception return.
- R7: When arith_signed is 1, an add (arith_sub=0) or subtract (arith_sub=1) whose two's-complement result overflows raises code 12. When arith_signed is 0 the same operands never raise an exception.
- R8: A register read, register write or exception return attempted in user mode raises code 10. The write is not performed, and ctl_rdata reads 0 in user mode.
- R9: Register indices are: 8 bad address, 12 status (bit 0 interrupt enable, bit 1 kernel mode, bits 13:8 interrupt masks, other bits 0), 13 cause (read-only), 14 exception PC. Any other index reads 0 and ignores writes. Read data appears in the same cycle as ctl_rd.
- R10: An exception return in kernel mode redirects, on the next edge, to the saved exception PC. It also sets kernel_mode to 0 and the interrupt enable to 1.
- R11: Nothing is taken or written without commit_valid. A register write on a committing instruction that also raises a synchronous exception is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_valid | input | 1 | An instruction commits this cycle |
| pc_cur | input | XLEN | Address of the committing instruction |
| pc_next | input | XLEN | Address of the instruction after it |
| fetch_addr_err | input | 1 | Fetch address error |
| fetch_bus_err | input | 1 | Fetch bus error |
| illegal_op | input | 1 | Undefined opcode |
| syscall_op | input | 1 | System call instruction |
| break_op | input | 1 | Breakpoint instruction |
| trap_hit | input | 1 | Trap instruction condition true |
| fpu_exc | input | 1 | Floating-point unit exception |
| load_addr_err | input | 1 | Load address error |
| store_addr_err | input | 1 | Store address error |
| data_bus_err | input | 1 | Load/store bus error |
| fault_addr | input | XLEN | Offending address for address errors |
| arith_signed | input | 1 | Instruction is a trapping signed add/subtract |
| arith_sub | input | 1 | 1 = subtract, 0 = add |
| arith_a | input | XLEN | First operand |
| arith_b | input | XLEN | Second operand |
| irq_in | input | NIRQ | External interrupt lines |
| ctl_rd | input | 1 | Control register read |
| ctl_wr | input | 1 | Control register write |
| ctl_idx | input | 5 | Control register index |
| ctl_wdata | input | XLEN | Write data |
| eret_op | input | 1 | Exception return |
| ctl_rdata | output | XLEN | Read data (combinational) |
| kernel_mode | output | 1 | 1 = kernel, 0 = user |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | XLEN | Redirect target |

## Verification
Every state change (mode, enable, cause, exception PC, bad address) and the redirect pulse lands on the first rising edge after the committing cycle. Register reads are combinational and valid in the cycle they are requested. The bench drives each commit on a falling edge and checks redirect_valid, redirect_pc and kernel_mode on the next falling edge, exactly one edge later. Between commits it reads every register index with commit_valid low, which cannot alter state, and compares each against a bench-side model of the register file.

// File: rtl/priv_exc_pkg.sv
package priv_exc_pkg;

  typedef enum logic [4:0] {
    EC_IRQ       = 5'd0,
    EC_ADDR_LD   = 5'd4,
    EC_ADDR_ST   = 5'd5,
    EC_BUS_FETCH = 5'd6,
    EC_BUS_DATA  = 5'd7,
    EC_SYSCALL   = 5'd8,
    EC_BREAK     = 5'd9,
    EC_RESERVED  = 5'd10,
    EC_OVERFLOW  = 5'd12,
    EC_TRAP      = 5'd13,
    EC_FPU       = 5'd15
  } exc_code_e;

  // synchronous sources, index 0 is highest priority
  localparam int unsigned NUM_SRC = 11;

  localparam int unsigned IDX_BAD    = 8;
  localparam int unsigned IDX_STATUS = 12;
  localparam int unsigned IDX_CAUSE  = 13;
  localparam int unsigned IDX_EPC    = 14;

  localparam int unsigned ST_IE       = 0;
  localparam int unsigned ST_KM       = 1;
  localparam int unsigned ST_MASK_LSB = 8;
  localparam int unsigned CA_LINE_LSB = 8;

  function automatic exc_code_e src_code(input int unsigned i);
    case (i)
      0:       return EC_ADDR_LD;
      1:       return EC_BUS_FETCH;
      2:       return EC_RESERVED;
      3:       return EC_OVERFLOW;
      4:       return EC_SYSCALL;
      5:       return EC_BREAK;
      6:       return EC_TRAP;
      7:       return EC_FPU;
      8:       return EC_ADDR_LD;
      9:       return EC_ADDR_ST;
      default: return EC_BUS_DATA;
    endcase
  endfunction

  // faults that restart the offending instruction
  function automatic logic restart_at_fault(input exc_code_e c);
    return (c == EC_ADDR_LD) || (c == EC_ADDR_ST) || (c == EC_BUS_FETCH) ||
           (c == EC_BUS_DATA) || (c == EC_RESERVED);
  endfunction

  function automatic logic records_bad_addr(input exc_code_e c);
    return (c == EC_ADDR_LD) || (c == EC_ADDR_ST);
  endfunction

endpackage

// File: rtl/exc_select.sv
module exc_select
  import priv_exc_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            irq_req,
  output logic            take,
  output logic            sync_take,
  output logic            irq_take,
  output exc_code_e       code
);

  logic [NSRC-1:0] grant;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (src[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    code = EC_IRQ;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (grant[i]) code = src_code(i);
    end
  end

  assign sync_take = |src;
  assign irq_take  = irq_req & ~sync_take;
  assign take      = sync_take | irq_take;

  // R3: a single synchronous winner
  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6: synchronous exceptions shadow interrupts
  a_r6_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (src != '0)) |-> !irq_take && (code != EC_IRQ));

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NIRQ = 6,
  parameter int unsigned LW   = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] mask,
  input  logic            ie,
  input  logic            allow,
  output logic            req,
  output logic [LW-1:0]   line
);

  logic [NIRQ-1:0] pend;

  assign pend = irq_in & mask;
  assign req  = allow & ie & (|pend);

  always_comb begin
    line = '0;
    for (int i = int'(NIRQ) - 1; i >= 0; i--) begin
      if (pend[i]) line = LW'(i);
    end
  end

  // R6: only an enabled, unmasked line, and the lowest one
  a_r6_lowest_line: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ie && irq_in[line] && mask[line] &&
            ((pend & ((NIRQ'(1) << line) - NIRQ'(1))) == '0));

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import priv_exc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NIRQ = 6,
  parameter int unsigned LW   = 3,
  parameter int unsigned IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  exc_code_e       code,
  input  logic            is_irq,
  input  logic [LW-1:0]   line,
  input  logic [XLEN-1:0] epc_val,
  input  logic            bad_we,
  input  logic [XLEN-1:0] bad_val,
  input  logic            leave,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wdata,
  input  logic [IDXW-1:0] rd_idx,
  output logic            kernel,
  output logic            ie,
  output logic [NIRQ-1:0] mask,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] rdata
);

  localparam logic [IDXW-1:0] I_BAD = IDXW'(IDX_BAD);
  localparam logic [IDXW-1:0] I_ST  = IDXW'(IDX_STATUS);
  localparam logic [IDXW-1:0] I_CA  = IDXW'(IDX_CAUSE);
  localparam logic [IDXW-1:0] I_EPC = IDXW'(IDX_EPC);

  exc_code_e       code_q;
  logic [LW-1:0]   line_q;
  logic [XLEN-1:0] bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kernel <= 1'b1;
      ie     <= 1'b0;
      mask   <= '0;
      code_q <= EC_IRQ;
      line_q <= '0;
      epc    <= '0;
      bad_q  <= '0;
    end else if (enter) begin
      kernel <= 1'b1;
      ie     <= 1'b0;
      code_q <= code;
      line_q <= is_irq ? line : '0;
      epc    <= epc_val;
      if (bad_we) bad_q <= bad_val;
    end else if (leave) begin
      kernel <= 1'b0;
      ie     <= 1'b1;
    end else if (wr_en) begin
      case (wr_idx)
        I_BAD: bad_q <= wdata;
        I_EPC: epc   <= wdata;
        I_ST: begin
          ie     <= wdata[ST_IE];
          kernel <= wdata[ST_KM];
          mask   <= wdata[ST_MASK_LSB +: NIRQ];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      I_BAD:   rdata = bad_q;
      I_EPC:   rdata = epc;
      I_ST:    rdata = (XLEN'(mask) << ST_MASK_LSB) | (XLEN'(kernel) << ST_KM) |
                       XLEN'(ie);
      I_CA:    rdata = (XLEN'(line_q) << CA_LINE_LSB) | XLEN'(code_q);
      default: rdata = '0;
    endcase
  end

  // R3: cause changes only on exception entry
  a_r3_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enter |=> $stable(code_q) && $stable(line_q));
  // R5: bad address moves only on address errors or a direct write
  a_r5_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter && bad_we) && !(!enter && !leave && wr_en && wr_idx == I_BAD)
    |=> $stable(bad_q));

endmodule

// File: rtl/priv_exc_unit.sv
module priv_exc_unit
  import priv_exc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned NIRQ        = 6,
  parameter logic [31:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_valid,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_next,
  input  logic            fetch_addr_err,
  input  logic            fetch_bus_err,
  input  logic            illegal_op,
  input  logic            syscall_op,
  input  logic            break_op,
  input  logic            trap_hit,
  input  logic            fpu_exc,
  input  logic            load_addr_err,
  input  logic            store_addr_err,
  input  logic            data_bus_err,
  input  logic [XLEN-1:0] fault_addr,
  input  logic            arith_signed,
  input  logic            arith_sub,
  input  logic [XLEN-1:0] arith_a,
  input  logic [XLEN-1:0] arith_b,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            ctl_rd,
  input  logic            ctl_wr,
  input  logic [4:0]      ctl_idx,
  input  logic [XLEN-1:0] ctl_wdata,
  input  logic            eret_op,
  output logic [XLEN-1:0] ctl_rdata,
  output logic            kernel_mode,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);

  localparam int unsigned LW   = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int unsigned IDXW = 5;
  localparam int unsigned MSB  = XLEN - 1;

  function automatic logic signed_ovf(input logic [XLEN-1:0] a,
                                      input logic [XLEN-1:0] b,
                                      input logic            sub);
    logic [XLEN-1:0] bb;
    logic [XLEN-1:0] r;
    bb = sub ? ~b : b;
    r  = a + bb + XLEN'(sub);
    return (a[MSB] == bb[MSB]) && (r[MSB] != a[MSB]);
  endfunction

  logic                ie;
  logic [NIRQ-1:0]     mask;
  logic [XLEN-1:0]     epc;
  logic [XLEN-1:0]     raw_rdata;
  logic                priv_viol;
  logic                ovf_hit;
  logic [NUM_SRC-1:0]  src;
  logic                irq_allow;
  logic                irq_req;
  logic [LW-1:0]       irq_line;
  logic                exc_take;
  logic                sync_take;
  logic                irq_take;
  exc_code_e           exc_code;
  logic                eret_fire;
  logic                wr_fire;
  logic [XLEN-1:0]     epc_pick;

  assign priv_viol = commit_valid & ~kernel_mode & (ctl_rd | ctl_wr | eret_op);
  assign ovf_hit   = arith_signed & signed_ovf(arith_a, arith_b, arith_sub);

  assign src = {NUM_SRC{commit_valid}} &
               {data_bus_err, store_addr_err, load_addr_err, fpu_exc, trap_hit,
                break_op, syscall_op, ovf_hit, illegal_op | priv_viol,
                fetch_bus_err, fetch_addr_err};

  assign irq_allow = commit_valid & ~ctl_wr & ~eret_op;

  irq_gate #(.NIRQ(NIRQ), .LW(LW)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask), .ie(ie),
    .allow(irq_allow), .req(irq_req), .line(irq_line)
  );

  exc_select #(.NSRC(NUM_SRC)) u_sel (
    .clk(clk), .rst_n(rst_n), .src(src), .irq_req(irq_req), .take(exc_take),
    .sync_take(sync_take), .irq_take(irq_take), .code(exc_code)
  );

  assign eret_fire = commit_valid & eret_op & kernel_mode & ~exc_take;
  assign wr_fire   = commit_valid & ctl_wr & kernel_mode & ~exc_take;
  assign epc_pick  = restart_at_fault(exc_code) ? pc_cur : pc_next;

  ctl_regs #(.XLEN(XLEN), .NIRQ(NIRQ), .LW(LW), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .enter(exc_take), .code(exc_code),
    .is_irq(irq_take), .line(irq_line), .epc_val(epc_pick),
    .bad_we(records_bad_addr(exc_code)), .bad_val(fault_addr),
    .leave(eret_fire), .wr_en(wr_fire), .wr_idx(ctl_idx), .wdata(ctl_wdata),
    .rd_idx(ctl_idx), .kernel(kernel_mode), .ie(ie), .mask(mask), .epc(epc),
    .rdata(raw_rdata)
  );

  assign ctl_rdata = (ctl_rd && kernel_mode) ? raw_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= exc_take | eret_fire;
      if (exc_take)       redirect_pc <= XLEN'(HANDLER_VEC);
      else if (eret_fire) redirect_pc <= epc;
    end
  end

  // R2: entry lands in kernel mode at the handler vector
  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> kernel_mode && redirect_valid && !ie &&
                 redirect_pc == XLEN'(HANDLER_VEC));
  // R4: faulting classes restart at the offending instruction
  a_r4_epc_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && restart_at_fault(exc_code)) |=> epc == $past(pc_cur));
  // R8: user access is refused
  a_r8_user_refused: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |=> kernel_mode && redirect_valid);
  // R10: return drops to user with interrupts open
  a_r10_eret: assert property (@(posedge clk) disable iff (!rst_n)
    eret_fire |=> !kernel_mode && ie && redirect_valid);
  // R11: no commit, no change
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |=> !redirect_valid && $stable(kernel_mode) && $stable(epc));

endmodule

// File: tb/priv_exc_unit_test.sv
`timescale 1ns/10ps
module priv_exc_unit_test;

  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit_valid, fetch_addr_err, fetch_bus_err, illegal_op, syscall_op;
  logic        break_op, trap_hit, fpu_exc, load_addr_err, store_addr_err, data_bus_err;
  logic        arith_signed, arith_sub, ctl_rd, ctl_wr, eret_op;
  logic [31:0] pc_cur, pc_next, fault_addr, arith_a, arith_b, ctl_wdata;
  logic [5:0]  irq_in;
  logic [4:0]  ctl_idx;
  logic [31:0] ctl_rdata, redirect_pc;
  logic        kernel_mode, redirect_valid;

  int checks = 0;
  int errors = 0;

  bit        m_kernel, m_ie;
  bit [5:0]  m_mask;
  bit [31:0] m_cause, m_epc, m_bad;

  always #2 clk = ~clk;

  priv_exc_unit uut (
    .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .pc_cur(pc_cur),
    .pc_next(pc_next), .fetch_addr_err(fetch_addr_err), .fetch_bus_err(fetch_bus_err),
    .illegal_op(illegal_op), .syscall_op(syscall_op), .break_op(break_op),
    .trap_hit(trap_hit), .fpu_exc(fpu_exc), .load_addr_err(load_addr_err),
    .store_addr_err(store_addr_err), .data_bus_err(data_bus_err),
    .fault_addr(fault_addr), .arith_signed(arith_signed), .arith_sub(arith_sub),
    .arith_a(arith_a), .arith_b(arith_b), .irq_in(irq_in), .ctl_rd(ctl_rd),
    .ctl_wr(ctl_wr), .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata), .eret_op(eret_op),
    .ctl_rdata(ctl_rdata), .kernel_mode(kernel_mode),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit b_ovf(input bit [31:0] a, input bit [31:0] b, input bit sub);
    longint r;
    r = sub ? (longint'($signed(a)) - longint'($signed(b)))
            : (longint'($signed(a)) + longint'($signed(b)));
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic clear_in();
    {commit_valid, fetch_addr_err, fetch_bus_err, illegal_op, syscall_op} = '0;
    {break_op, trap_hit, fpu_exc, load_addr_err, store_addr_err, data_bus_err} = '0;
    {arith_signed, arith_sub, ctl_rd, ctl_wr, eret_op} = '0;
    arith_a = '0; arith_b = '0; ctl_wdata = '0; irq_in = '0; ctl_idx = '0;
    pc_cur = $urandom & ~32'h3;
    pc_next = pc_cur + 32'd4;
    fault_addr = $urandom;
  endtask

  // one commit cycle: predict, clock, check one edge later, update model
  task automatic run(input string tag);
    bit priv, irq, eret_ok, wr_ok;
    int code, line;
    bit [31:0] exp_pc;
    string rq;
    priv = commit_valid && !m_kernel && (ctl_rd || ctl_wr || eret_op);
    code = -1; irq = 0; line = 0;
    if (commit_valid) begin
      if (fetch_addr_err)              code = 4;
      else if (fetch_bus_err)          code = 6;
      else if (illegal_op || priv)     code = 10;
      else if (arith_signed && b_ovf(arith_a, arith_b, arith_sub)) code = 12;
      else if (syscall_op)             code = 8;
      else if (break_op)               code = 9;
      else if (trap_hit)               code = 13;
      else if (fpu_exc)                code = 15;
      else if (load_addr_err)          code = 4;
      else if (store_addr_err)         code = 5;
      else if (data_bus_err)           code = 7;
    end
    if (commit_valid && code < 0 && m_ie && !ctl_wr && !eret_op)
      for (int i = 5; i >= 0; i--)
        if (irq_in[i] && m_mask[i]) begin irq = 1; line = i; end
    if (irq) code = 0;
    eret_ok = commit_valid && eret_op && m_kernel && code < 0;
    wr_ok   = commit_valid && ctl_wr && m_kernel && code < 0;
    exp_pc  = (code >= 0) ? VEC : m_epc;
    if (priv) rq = "R8";
    else if (code == 12) rq = "R7";
    else if (irq) rq = "R6";
    else if (code >= 0) rq = "R2";
    else if (eret_ok) rq = "R10";
    else rq = "R11";
    @(posedge clk);
    @(negedge clk);
    chk(rq, {tag, " redirect_valid"}, 32'(redirect_valid), 32'(code >= 0 || eret_ok));
    if (code >= 0 || eret_ok) chk(rq, {tag, " redirect_pc"}, redirect_pc, exp_pc);
    if (code >= 0) begin
      m_kernel = 1; m_ie = 0;
      m_cause = 32'(code) | (irq ? (32'(line) << 8) : 32'd0);
      m_epc = (code inside {4, 5, 6, 7, 10}) ? pc_cur : pc_next;
      if (code == 4 || code == 5) m_bad = fault_addr;
    end else if (eret_ok) begin
      m_kernel = 0; m_ie = 1;
    end else if (wr_ok) begin
      case (ctl_idx)
        5'd8:  m_bad = ctl_wdata;
        5'd14: m_epc = ctl_wdata;
        5'd12: begin m_ie = ctl_wdata[0]; m_kernel = ctl_wdata[1]; m_mask = ctl_wdata[13:8]; end
        default: ;
      endcase
    end
    chk(rq, {tag, " kernel_mode"}, 32'(kernel_mode), 32'(m_kernel));
  endtask

  // reads with commit low cannot change state
  task automatic read_all(input string tag);
    int idxs[5] = '{8, 12, 13, 14, 3};
    clear_in();
    ctl_rd = 1;
    if (m_kernel) begin
      foreach (idxs[k]) begin
        ctl_idx = 5'(idxs[k]);
        #0.2;
        case (idxs[k])
          8:  chk("R5", {tag, " bad addr"}, ctl_rdata, m_bad);
          12: chk("R9", {tag, " status"}, ctl_rdata,
                  (32'(m_mask) << 8) | (32'(m_kernel) << 1) | 32'(m_ie));
          13: chk("R3", {tag, " cause"}, ctl_rdata, m_cause);
          14: chk("R4", {tag, " epc"}, ctl_rdata, m_epc);
          default: chk("R9", {tag, " unmapped"}, ctl_rdata, 32'd0);
        endcase
      end
    end else begin
      ctl_idx = 5'd12;
      #0.2;
      chk("R8", {tag, " user read"}, ctl_rdata, 32'd0);
    end
    clear_in();
  endtask

  task automatic wr_status(input bit [31:0] v);
    clear_in(); commit_valid = 1; ctl_wr = 1; ctl_idx = 5'd12; ctl_wdata = v;
    run("status write");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_in();
    m_kernel = 1; m_ie = 0; m_mask = 0; m_cause = 0; m_epc = 0; m_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset redirect_valid", 32'(redirect_valid), 32'd0);
    chk("R1", "reset kernel_mode", 32'(kernel_mode), 32'd1);
    read_all("R1 reset");

    // R7 unsigned never traps, signed does
    wr_status(32'h0000_3F03);
    clear_in(); commit_valid = 1; arith_a = 32'h7FFF_FFFF; arith_b = 32'd1;
    run("R7 unsigned add"); read_all("R7");
    clear_in(); commit_valid = 1; arith_signed = 1; arith_a = 32'h7FFF_FFFF; arith_b = 32'd1;
    run("R7 signed add"); read_all("R7");
    clear_in(); commit_valid = 1; arith_signed = 1; arith_sub = 1;
    arith_a = 32'h0; arith_b = 32'h8000_0000;
    run("R7 signed sub"); read_all("R7");

    // R6 lowest enabled line wins, masked lines ignored
    wr_status(32'h0000_3F03);
    clear_in(); commit_valid = 1; irq_in = 6'b101000;
    run("R6 two lines"); read_all("R6");
    wr_status(32'h0000_1F03);
    clear_in(); commit_valid = 1; irq_in = 6'b100000;
    run("R6 masked line"); read_all("R6");
    clear_in(); commit_valid = 1; irq_in = 6'b000001; ctl_wr = 1; ctl_idx = 5'd14;
    ctl_wdata = 32'h1234_5678;
    run("R6 deferred by write"); read_all("R6");
    clear_in(); commit_valid = 1; irq_in = 6'b000001; syscall_op = 1;
    run("R6 sync beats irq"); read_all("R6");

    // R4 / R5 fault classes and priority
    clear_in(); commit_valid = 1; fetch_bus_err = 1;
    run("R4 fetch bus"); read_all("R4");
    clear_in(); commit_valid = 1; store_addr_err = 1;
    run("R5 store addr"); read_all("R5");
    clear_in(); commit_valid = 1; fetch_addr_err = 1; data_bus_err = 1; break_op = 1;
    run("R3 priority"); read_all("R3");
    clear_in(); commit_valid = 1; trap_hit = 1; fpu_exc = 1; data_bus_err = 1;
    run("R3 trap over fpu"); read_all("R3");

    // R9 cause read-only, unmapped write ignored
    clear_in(); commit_valid = 1; ctl_wr = 1; ctl_idx = 5'd13; ctl_wdata = 32'hFFFF_FFFF;
    run("R9 cause write"); read_all("R9");
    clear_in(); commit_valid = 1; ctl_wr = 1; ctl_idx = 5'd3; ctl_wdata = 32'hFFFF_FFFF;
    run("R9 unmapped write"); read_all("R9");

    // R11 no commit, and write lost to a simultaneous exception
    clear_in(); syscall_op = 1; ctl_wr = 1; ctl_idx = 5'd14; ctl_wdata = 32'hDEAD_0000;
    run("R11 no commit"); read_all("R11");
    clear_in(); commit_valid = 1; break_op = 1; ctl_wr = 1; ctl_idx = 5'd8;
    ctl_wdata = 32'hDEAD_BEEF;
    run("R11 write suppressed"); read_all("R11");

    // R10 return, then R8 refusals in user mode
    clear_in(); commit_valid = 1; eret_op = 1;
    run("R10 eret"); read_all("R10");
    clear_in(); commit_valid = 1; ctl_wr = 1; ctl_idx = 5'd14; ctl_wdata = 32'h0BAD_0BAD;
    run("R8 user write"); read_all("R8");
    clear_in(); commit_valid = 1; eret_op = 1;
    run("R10 eret"); read_all("R10");
    clear_in(); commit_valid = 1; eret_op = 1;
    run("R8 user eret"); read_all("R8");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      clear_in();
      commit_valid   = ($urandom_range(3) != 0);
      fetch_addr_err = ($urandom_range(24) == 0);
      fetch_bus_err  = ($urandom_range(24) == 0);
      illegal_op     = ($urandom_range(24) == 0);
      syscall_op     = ($urandom_range(20) == 0);
      break_op       = ($urandom_range(20) == 0);
      trap_hit       = ($urandom_range(20) == 0);
      fpu_exc        = ($urandom_range(20) == 0);
      load_addr_err  = ($urandom_range(20) == 0);
      store_addr_err = ($urandom_range(20) == 0);
      data_bus_err   = ($urandom_range(20) == 0);
      arith_signed   = $urandom_range(1);
      arith_sub      = $urandom_range(1);
      arith_a        = ($urandom_range(1) != 0) ? ($urandom | 32'h4000_0000) : $urandom_range(255);
      arith_b        = ($urandom_range(1) != 0) ? ($urandom | 32'h4000_0000) : $urandom_range(255);
      irq_in         = ($urandom_range(2) == 0) ? 6'($urandom) : 6'd0;
      op = $urandom_range(9);
      if (op == 0) ctl_rd = 1;
      else if (op <= 2) begin
        int sel;
        ctl_wr = 1;
        sel = $urandom_range(4);
        ctl_idx = (sel == 0) ? 5'd8 : (sel == 1) ? 5'd14 : (sel == 2) ? 5'd13 :
                  (sel == 3) ? 5'd3 : 5'd12;
        ctl_wdata = $urandom;
        if (ctl_idx == 5'd12) ctl_wdata[1] = ($urandom_range(3) == 0) ? 1'b0 : 1'b1;
      end else if (op == 3) eret_op = 1;
      run("random");
      read_all("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule